// File: doc/BRIEF.md
# Programmable Logic Array

A two-level sum-of-products array in which the AND plane and the OR plane can both be programmed. The connection bits sit in registers. Every one of the `N_IN` input variables goes to each of the `N_TERM` product terms twice, once as itself and once inverted. Each product term can feed any number of the `N_OUT` outputs. After its wide OR, each output passes through an inversion stage that can be switched on or off.

Configuration is loaded one bit per clock through a small addressed write port. The write names a plane, a row and a column. Between the inputs and the outputs there is no register at all, so the outputs follow the inputs combinationally from whatever configuration is stored. After reset every connection is intact and no output is inverted. The default size is 4 inputs, 6 product terms and 3 outputs.

Top module: `pla_core`

## Requirements
- R1: Product term t equals the AND of all the literals connected to it. AND-plane column 2v is input v in true form and column 2v+1 is input v inverted. A term with no literals connected evaluates to 1.
- R2: A product term with both literals of any one variable connected evaluates to 0. The fully intact array therefore drives 0 on every output whose inversion bit is clear.
- R3: Output k is the OR of every product term whose OR-plane bit (row t, column k) is set. One term can feed several outputs.
- R4: When the inversion bit of output k is 1, the output is the complement of its OR.
- R5: An output with no product terms connected is 0 before inversion, so it shows its inversion bit.
- R6: A write with `cfg_we_i`=1 stores `cfg_bit_i` at the next rising clock edge. Plane 0 is the AND plane (row = term, column = literal). Plane 1 is the OR plane (row = term, column = output). Plane 2 is the inversion bits (column = output, row ignored). Before that edge the outputs are unchanged.
- R7: The write is ignored when the plane is 3, the row is at or above `N_TERM` for planes 0 and 1, or the column is out of range for the selected plane.
- R8: Asserting the active-low asynchronous reset sets every AND and OR connection to intact (1) and clears every inversion bit.
- R9: The outputs follow input changes within the same clock cycle, with no register stage.
- R10: At the default size, with variables A, B and C on inputs 2, 1 and 0, the array can hold F1 = Σm(2,4,5,7) and F2 = Σm(0,1,2,4,6) on shared product terms, plus the complement of F1 on a third output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration writes |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_plane_i | input | 2 | Plane select: 0 AND, 1 OR, 2 inversion, 3 reserved |
| cfg_row_i | input | ROW_W | Product term index |
| cfg_col_i | input | COL_W | Literal index (AND plane) or output index (OR plane, inversion) |
| cfg_bit_i | input | 1 | Value written (1 = connected / inverted) |
| in_i | input | N_IN | Input variables |
| out_o | output | N_OUT | Array outputs |

## Verification
The bench first sweeps all input patterns over the intact array. A design that let contradictory terms through, or treated intact as disconnected, would show a 1 there. It then programs the two shared-term functions and checks every minterm against arithmetic masks. A wrong literal column order would scramble the functions, and broken term sharing would lose minterms on one output. Targeted writes cover a term with no literals (expected 1), an output with no terms (expected to show only its inversion bit), and out-of-range row, column and plane codes, which must leave every output untouched. A mid-run reset must bring the array back to its intact all-zero state.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    PLANE_AND = 2'd0,
    PLANE_OR  = 2'd1,
    PLANE_POL = 2'd2,
    PLANE_RSV = 2'd3
  } plane_e;

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              bit_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_TERM-1:0] term_o
);

  localparam int N_LIT = 2 * N_IN;

  logic [N_TERM-1:0][N_LIT-1:0] cfg_q;
  logic [N_LIT-1:0]             lit;
  logic                         wr_ok;

  assign wr_ok = we_i && (int'(row_i) < N_TERM) && (int'(col_i) < N_LIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '1;
    end else if (wr_ok) begin
      cfg_q[row_i][col_i] <= bit_i;
    end
  end

  // even column = true literal, odd column = complement
  for (genvar v = 0; v < N_IN; v++) begin : g_lit
    assign lit[2*v]   = in_i[v];
    assign lit[2*v+1] = ~in_i[v];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    assign term_o[t] = &(~cfg_q[t] | lit);

    logic [N_IN-1:0] clash;
    for (genvar v = 0; v < N_IN; v++) begin : g_clash
      assign clash[v] = cfg_q[t][2*v] & cfg_q[t][2*v+1];
    end

    a_r2_contradiction: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|clash) |-> !term_o[t]);
  end

  a_r6_and_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> cfg_q[$past(row_i)][$past(col_i)] == $past(bit_i));

  a_r7_and_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok |=> $stable(cfg_q));

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conn_we_i,
  input  logic              pol_we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              bit_i,
  input  logic [N_TERM-1:0] term_i,
  output logic [N_OUT-1:0]  dat_o
);

  logic [N_TERM-1:0][N_OUT-1:0] conn_q;
  logic [N_OUT-1:0]             pol_q;
  logic                         conn_ok;
  logic                         pol_ok;

  assign conn_ok = conn_we_i && (int'(row_i) < N_TERM) && (int'(col_i) < N_OUT);
  assign pol_ok  = pol_we_i && (int'(col_i) < N_OUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= '1;
      pol_q  <= '0;
    end else begin
      if (conn_ok) conn_q[row_i][col_i] <= bit_i;
      if (pol_ok)  pol_q[col_i]         <= bit_i;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_TERM-1:0] sel;
    for (genvar t = 0; t < N_TERM; t++) begin : g_sel
      assign sel[t] = conn_q[t][k];
    end
    assign dat_o[k] = (|(sel & term_i)) ^ pol_q[k];

    a_r5_empty_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == '0) |-> (dat_o[k] == pol_q[k]));
  end

  a_r6_or_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conn_ok |=> conn_q[$past(row_i)][$past(col_i)] == $past(bit_i));

  a_r4_pol_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_ok |=> pol_q[$past(col_i)] == $past(bit_i));

  a_r7_or_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conn_ok || pol_ok) |=> ($stable(conn_q) && $stable(pol_q)));

endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int  N_IN   = 4,
  parameter int  N_TERM = 6,
  parameter int  N_OUT  = 3,
  localparam int ROW_W  = idx_w(N_TERM),
  localparam int COL_W  = idx_w(max2(2 * N_IN, N_OUT))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_plane_i,
  input  logic [ROW_W-1:0] cfg_row_i,
  input  logic [COL_W-1:0] cfg_col_i,
  input  logic             cfg_bit_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o
);

  plane_e            plane;
  logic              and_we;
  logic              or_we;
  logic              pol_we;
  logic [N_TERM-1:0] term;

  assign plane  = plane_e'(cfg_plane_i);
  assign and_we = cfg_we_i && (plane == PLANE_AND);
  assign or_we  = cfg_we_i && (plane == PLANE_OR);
  assign pol_we = cfg_we_i && (plane == PLANE_POL);

  pla_and_plane #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_and (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (and_we),
    .row_i  (cfg_row_i),
    .col_i  (cfg_col_i),
    .bit_i  (cfg_bit_i),
    .in_i   (in_i),
    .term_o (term)
  );

  pla_or_plane #(
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_or (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .conn_we_i (or_we),
    .pol_we_i  (pol_we),
    .row_i     (cfg_row_i),
    .col_i     (cfg_col_i),
    .bit_i     (cfg_bit_i),
    .term_i    (term),
    .dat_o     (out_o)
  );

  a_r1_onehot_plane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({and_we, or_we, pol_we}));

endmodule

// File: tb/pla_core_tb_top.sv
module pla_core_tb_top;

  localparam int N_IN = 4, N_TERM = 6, N_OUT = 3;
  localparam int ROW_W = 3, COL_W = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [1:0]       cfg_plane_i = '0;
  logic [ROW_W-1:0] cfg_row_i = '0;
  logic [COL_W-1:0] cfg_col_i = '0;
  logic             cfg_bit_i = 1'b0;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_OUT-1:0] out_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2*N_IN-1:0] and_m [N_TERM];
  logic [N_OUT-1:0]  or_m  [N_TERM];
  logic [N_OUT-1:0]  inv_m;

  always #10 clk = ~clk;

  pla_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_plane_i(cfg_plane_i),
    .cfg_row_i(cfg_row_i), .cfg_col_i(cfg_col_i), .cfg_bit_i(cfg_bit_i),
    .in_i(in_i), .out_o(out_o)
  );

  task automatic chk(input string tag, input logic [N_OUT-1:0] got, input logic [N_OUT-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < N_TERM; t++) begin
      and_m[t] = '1;
      or_m[t]  = '1;
    end
    inv_m = '0;
  endtask

  function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x);
    logic [N_OUT-1:0] acc = '0;
    for (int t = 0; t < N_TERM; t++) begin
      logic p = 1'b1;
      for (int v = 0; v < N_IN; v++) begin
        if (and_m[t][2*v] && !x[v]) p = 1'b0;
        if (and_m[t][2*v+1] && x[v]) p = 1'b0;
      end
      if (p) acc = acc | or_m[t];
    end
    return acc ^ inv_m;
  endfunction

  // one write per clock; model follows only legal addresses
  task automatic wr(input int plane, input int row, input int col, input logic b);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_plane_i = 2'(plane); cfg_row_i = 3'(row);
    cfg_col_i = 3'(col); cfg_bit_i = b;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (plane == 0 && row < N_TERM && col < 2*N_IN) and_m[row][col] = b;
    if (plane == 1 && row < N_TERM && col < N_OUT) or_m[row][col] = b;
    if (plane == 2 && col < N_OUT) inv_m[col] = b;
  endtask

  task automatic sweep(input string tag);
    for (int x = 0; x < (1 << N_IN); x++) begin
      in_i = 4'(x);
      #1;
      chk(tag, out_o, model(4'(x)));
    end
  endtask

  task automatic load_term(input int t, input logic [7:0] lits, input logic [2:0] outs);
    for (int c = 0; c < 2*N_IN; c++) wr(0, t, c, lits[c]);
    for (int k = 0; k < N_OUT; k++) wr(1, t, k, outs[k]);
  endtask

  initial begin
    logic [7:0] f1 = 8'b1011_0100;
    logic [7:0] f2 = 8'b0101_0111;
    logic [N_OUT-1:0] snap;
    model_reset();
    #5;
    #1 chk("R8 reset out", out_o, 3'b000);
    @(negedge clk); rst_ni = 1'b1;

    sweep("R2 intact array");

    // R6: value visible only after the edge
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_plane_i = 2'd2; cfg_col_i = 3'd1; cfg_bit_i = 1'b1; in_i = '0;
    #1 chk("R6 before edge", out_o, 3'b000);
    @(negedge clk); cfg_we_i = 1'b0; inv_m[1] = 1'b1;
    #1 chk("R6 after edge", out_o, 3'b010);
    sweep("R4 inversion on intact");
    wr(2, 0, 1, 1'b0);

    // F1 = A'BC' + AB' + AC, F2 = C' + A'B', out2 = ~F1
    load_term(0, 8'b0010_0110, 3'b101);
    load_term(1, 8'b0001_1000, 3'b101);
    load_term(2, 8'b0001_0001, 3'b101);
    load_term(3, 8'b0000_0010, 3'b010);
    load_term(4, 8'b0010_1000, 3'b010);
    wr(2, 0, 2, 1'b1);
    sweep("R3 shared terms model");
    for (int x = 0; x < 16; x++) begin
      in_i = 4'(x);
      #1 chk("R10 F1/F2/~F1", out_o, {~f1[x[2:0]], f2[x[2:0]], f1[x[2:0]]});
    end

    // R9: input change seen before any clock edge
    @(negedge clk);
    in_i = 4'd2; #1 chk("R9 comb a", out_o, model(4'd2));
    in_i = 4'd3; #1 chk("R9 comb b", out_o, model(4'd3));

    // R7: illegal addresses leave the outputs alone
    snap = model(4'd5);
    wr(0, 6, 0, 1'b0);
    wr(1, 7, 0, 1'b0);
    wr(1, 0, 3, 1'b0);
    wr(2, 0, 3, 1'b1);
    wr(3, 0, 0, 1'b0);
    wr(3, 3, 1, 1'b1);
    in_i = 4'd5; #1 chk("R7 ignored single", out_o, snap);
    sweep("R7 ignored sweep");

    // R1: term with no literals is 1
    for (int c = 0; c < 8; c++) wr(0, 5, c, 1'b0);
    sweep("R1 empty term");
    in_i = 4'd0; #1 chk("R1 empty term on", out_o, 3'b011);

    // R5: output with no terms shows its inversion bit
    for (int t = 0; t < N_TERM; t++) wr(1, t, 2, 1'b0);
    sweep("R5 empty or inv1");
    wr(2, 0, 2, 1'b0);
    sweep("R5 empty or inv0");
    in_i = 4'd9; #1 chk("R5 out2 zero", {out_o[2], 2'b00}, 3'b000);

    // R8: mid-run reset restores intact
    #3 rst_ni = 1'b0; model_reset();
    #1 chk("R8 async reset", out_o, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    sweep("R8 intact after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule